// File: doc/BRIEF.md
# Seven-to-one LVDS pixel packer with selectable bit map

This block turns one parallel pixel per pixel period into four serial data lanes and one forwarded clock lane. It runs entirely on the fast bit clock, which is seven times the pixel rate. An internal phase counter splits the bit clock into seven-bit frames. Once per frame it raises a load strobe. The upstream pixel source must present red, green and blue (eight bits each) and a data-enable flag while that strobe is high.

At the bit-clock edge that ends the strobe cycle, the pixel is placed into 28 numbered slots. Lane k carries slots 7k to 7k+6, and the lowest slot goes out first. The clock lane sends a fixed two-high, three-low, two-high shape in step with the lane frames.

A static format selector picks between two placements. In the first, the six low colour bits fill the main slots and the two top bits fill the spare slots. In the second, every colour is rotated down by two bit positions before placement, so the two low bits land in the spare slots instead. The selector is only taken in frames where data-enable is low, so the map never changes partway through an active line. Sync positions do not exist in this data path: the three slots reserved for them are always driven low.

Top module: `lvds_pack_tx`

## Requirements
- R1: After reset, all lanes and the clock lane are low and `load_o` is low. `load_o` first rises in the sixth bit-clock cycle after reset is released, and from then on it is high for exactly one cycle in every seven.
- R2: The pixel that is present while `load_o` is high is sent in the seven cycles that follow the load edge. In the j-th of these cycles (j = 0..6), lane k carries slot 7k+j.
- R3: With the map selector at 0, the slots carry: slots 0-4 = R0-R4, 5 = R7, 6 = R5, 7-9 = G0-G2, 10 = G6, 11 = G7, 12-14 = G3-G5, 15 = B0, 16 = B6, 17 = B7, 18-22 = B1-B5, 27 = R6.
- R4: With the map selector at 1, every colour bit index in the R3 map is raised by two, modulo 8. So slots 0-4 = R2-R6, 5 = R1, 6 = R7, 10 = G0, 11 = G1, 16 = B0, 17 = B1, 27 = R0, and the G and B runs shift in the same way.
- R5: Slots 23, 24 and 25 (lane 3, positions 2 to 4) are always low, whatever the colour inputs are.
- R6: Slot 26 (lane 3, position 5) carries the data-enable value that was loaded with the pixel.
- R7: In every frame the clock lane sends 1,1,0,0,0,1,1 in the same seven cycles as the lane frame.
- R8: The map selector is taken only at loads where data-enable is low, and it applies from that pixel onward. At loads where data-enable is high, the last taken selector value (0 after reset) stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| red_i | input | 8 | Red component |
| grn_i | input | 8 | Green component |
| blu_i | input | 8 | Blue component |
| de_i | input | 1 | Data enable of the pixel |
| fmt_sel_i | input | 1 | Map selector (0: low bits in main slots, 1: rotated by two) |
| load_o | output | 1 | High in the cycle where the pixel inputs are captured |
| lane_o | output | 4 | Serial data lanes, bit k is lane k |
| clk_pat_o | output | 1 | Forwarded clock pattern lane |

## Verification
A walking single one is driven through each of the 24 colour bits, under both maps. This catches any slot that is swapped, duplicated or misplaced, because exactly one slot of the recovered 28-bit word may be high. An all-ones pixel shows that the reserved slots stay low even when every neighbour is high, and the alternating 0xA5/0x5A values expose swapped lanes or a reversed bit order within a lane. A sequence that toggles the selector while data-enable is high, and then again while it is low, separates a selector that is correctly gated from one that is sampled on every frame.

// File: rtl/lvds_pack_tx.sv
module lvds_pack_tx #(
  parameter int unsigned    LANES = 4,
  parameter int unsigned    FRAME = 7,
  parameter logic [6:0]     CLK_SHAPE = 7'b1100011
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic [7:0]        red_i,
  input  logic [7:0]        grn_i,
  input  logic [7:0]        blu_i,
  input  logic              de_i,
  input  logic              fmt_sel_i,
  output logic              load_o,
  output logic [LANES-1:0]  lane_o,
  output logic              clk_pat_o
);
  localparam int unsigned PW    = $clog2(FRAME);
  localparam int unsigned SLOTS = LANES * FRAME;

  logic [PW-1:0]    phase;
  logic             fmt_q;
  logic             fmt_use;
  logic [7:0]       r_m, g_m, b_m;
  logic [SLOTS-1:0] word;
  logic [FRAME-1:0] sh [LANES];
  logic [FRAME-1:0] sh_clk;

  function automatic logic [7:0] rot2(input logic [7:0] c);
    return {c[1:0], c[7:2]};
  endfunction

  assign load_o  = (phase == PW'(FRAME - 1));
  assign fmt_use = de_i ? fmt_q : fmt_sel_i;
  assign r_m     = fmt_use ? rot2(red_i) : red_i;
  assign g_m     = fmt_use ? rot2(grn_i) : grn_i;
  assign b_m     = fmt_use ? rot2(blu_i) : blu_i;

  always_comb begin
    word          = '0;
    word[4:0]     = r_m[4:0];
    word[5]       = r_m[7];
    word[6]       = r_m[5];
    word[9:7]     = g_m[2:0];
    word[10]      = g_m[6];
    word[11]      = g_m[7];
    word[14:12]   = g_m[5:3];
    word[15]      = b_m[0];
    word[16]      = b_m[6];
    word[17]      = b_m[7];
    word[22:18]   = b_m[5:1];
    word[26]      = de_i;
    word[27]      = r_m[6];
  end

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      fmt_q  <= 1'b0;
      sh_clk <= '0;
      for (int k = 0; k < LANES; k++) sh[k] <= '0;
    end else if (load_o) begin
      phase  <= '0;
      if (!de_i) fmt_q <= fmt_sel_i;
      sh_clk <= CLK_SHAPE;
      for (int k = 0; k < LANES; k++) sh[k] <= word[k*FRAME +: FRAME];
    end else begin
      phase  <= phase + PW'(1);
      sh_clk <= sh_clk >> 1;
      for (int k = 0; k < LANES; k++) sh[k] <= sh[k] >> 1;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_o[k] = sh[k][0];
  end
  assign clk_pat_o = sh_clk[0];
endmodule

// File: rtl/lvds_pack_tx_chk.sv
module lvds_pack_tx_chk (
  input logic       clk_bit,
  input logic       rst_n,
  input logic       load_o,
  input logic       de_i,
  input logic [3:0] lane_o,
  input logic       clk_pat_o
);
  localparam logic [6:0] SHAPE = 7'b1100011;

  logic       started;
  logic [2:0] pos;
  logic       de_q;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      pos     <= '0;
      de_q    <= 1'b0;
    end else if (load_o) begin
      started <= 1'b1;
      pos     <= '0;
      de_q    <= de_i;
    end else if (pos != 3'd6) begin
      pos <= pos + 3'd1;
    end
  end

  AST_LOAD_SINGLE: assert property (@(posedge clk_bit) disable iff (!rst_n)
    load_o |=> !load_o); // R1
  AST_LOAD_PERIOD: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (started && pos == 3'd6) |-> load_o); // R1
  AST_QUIET_START: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !started |-> (lane_o == 4'd0 && !clk_pat_o)); // R1
  AST_CLK_SHAPE: assert property (@(posedge clk_bit) disable iff (!rst_n)
    started |-> (clk_pat_o == SHAPE[pos])); // R7
  AST_RSVD_LOW: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (started && pos >= 3'd2 && pos <= 3'd4) |-> !lane_o[3]); // R5
  AST_DE_SLOT: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (started && pos == 3'd5) |-> (lane_o[3] == de_q)); // R6
endmodule

bind lvds_pack_tx lvds_pack_tx_chk u_chk (
  .clk_bit(clk_bit), .rst_n(rst_n), .load_o(load_o), .de_i(de_i),
  .lane_o(lane_o), .clk_pat_o(clk_pat_o)
);

// File: tb/lvds_pack_tx_test.sv
`timescale 1ns/1ps
module lvds_pack_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] red = '0, grn = '0, blu = '0;
  logic       de = 1'b0, fmt = 1'b0;
  logic       load;
  logic [3:0] lane;
  logic       cpat;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  lvds_pack_tx uut (
    .clk_bit(clk), .rst_n(rst_n), .red_i(red), .grn_i(grn), .blu_i(blu),
    .de_i(de), .fmt_sel_i(fmt), .load_o(load), .lane_o(lane), .clk_pat_o(cpat)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] expect_word(input logic [7:0] r, g, b, input logic d, input logic f);
    logic [27:0] w;
    w = '0;
    w[26] = d;
    if (!f) begin
      for (int i = 0; i < 5; i++) w[i] = r[i];
      w[5] = r[7]; w[6] = r[5]; w[27] = r[6];
      for (int i = 0; i < 3; i++) begin w[7+i] = g[i]; w[12+i] = g[3+i]; end
      w[10] = g[6]; w[11] = g[7];
      w[15] = b[0]; w[16] = b[6]; w[17] = b[7];
      for (int i = 0; i < 5; i++) w[18+i] = b[1+i];
    end else begin
      for (int i = 0; i < 5; i++) w[i] = r[2+i];
      w[5] = r[1]; w[6] = r[7]; w[27] = r[0];
      for (int i = 0; i < 3; i++) begin w[7+i] = g[2+i]; w[12+i] = g[5+i]; end
      w[10] = g[0]; w[11] = g[1];
      w[15] = b[2]; w[16] = b[0]; w[17] = b[1];
      for (int i = 0; i < 5; i++) w[18+i] = b[3+i];
    end
    return w;
  endfunction

  task automatic send(input logic [7:0] r, g, b, input logic d, input logic f,
                      output logic [27:0] w, output logic [6:0] cp);
    while (!load) @(negedge clk);
    red = r; grn = g; blu = b; de = d; fmt = f;
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) w[7*k+j] = lane[k];
      cp[j] = cpat;
    end
  endtask

  task automatic send_check(input logic [7:0] r, g, b, input logic d, input logic f,
                            input logic fexp, input string req);
    logic [27:0] w;
    logic [6:0]  cp;
    logic [27:0] e;
    send(r, g, b, d, f, w, cp);
    e = expect_word(r, g, b, d, fexp);
    check(w == e, req, {4'h0, w}, {4'h0, e});
    check(w[25:23] == 3'b000, "R5", {29'h0, w[25:23]}, 32'h0);
    check(w[26] == d, "R6", {31'h0, w[26]}, {31'h0, d});
    check(cp == 7'b1100011, "R7", {25'h0, cp}, 32'h63);
  endtask

  task automatic t_reset;
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(lane == 4'd0, "R1", {28'h0, lane}, 32'h0);
    check(cpat == 1'b0, "R1", {31'h0, cpat}, 32'h0);
    check(load == 1'b0, "R1", {31'h0, load}, 32'h0);
    rst_n = 1'b1;
    n = 0;
    while (!load && n < 20) begin @(negedge clk); n++; end
    check(n == 6, "R1", n, 6);
    check(lane == 4'd0 && cpat == 1'b0, "R1", {27'h0, cpat, lane}, 32'h0);
    @(negedge clk);
    n = 1;
    while (!load && n < 20) begin @(negedge clk); n++; end
    check(n == 7, "R1", n, 7);
  endtask

  task automatic t_map_low;
    for (int i = 0; i < 8; i++) begin
      send_check(8'h1 << i, 8'h0, 8'h0, 1'b1, 1'b0, 1'b0, "R3 red");
      send_check(8'h0, 8'h1 << i, 8'h0, 1'b1, 1'b0, 1'b0, "R3 green");
      send_check(8'h0, 8'h0, 8'h1 << i, 1'b1, 1'b0, 1'b0, "R3 blue");
    end
    send_check(8'hA5, 8'h5A, 8'hC3, 1'b1, 1'b0, 1'b0, "R2 R3 mixed");
  endtask

  task automatic t_map_high;
    send_check(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, "R4 select");
    for (int i = 0; i < 8; i++) begin
      send_check(8'h1 << i, 8'h0, 8'h0, 1'b1, 1'b1, 1'b1, "R4 red");
      send_check(8'h0, 8'h1 << i, 8'h0, 1'b1, 1'b1, 1'b1, "R4 green");
      send_check(8'h0, 8'h0, 8'h1 << i, 1'b1, 1'b1, 1'b1, "R4 blue");
    end
    send_check(8'h5A, 8'hA5, 8'h3C, 1'b1, 1'b1, 1'b1, "R2 R4 mixed");
  endtask

  task automatic t_reserved;
    send_check(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, "R5 all ones");
    send_check(8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, "R5 R6 de low");
  endtask

  task automatic t_fmt_hold;
    send_check(8'h01, 8'h02, 8'h80, 1'b0, 1'b0, 1'b0, "R8 take 0");
    send_check(8'h01, 8'h02, 8'h80, 1'b1, 1'b1, 1'b0, "R8 ignore 1");
    send_check(8'h40, 8'h08, 8'h01, 1'b1, 1'b1, 1'b0, "R8 still 0");
    send_check(8'h40, 8'h08, 8'h01, 1'b0, 1'b1, 1'b1, "R8 take 1");
    send_check(8'h81, 8'h42, 8'h24, 1'b1, 1'b0, 1'b1, "R8 ignore 0");
    send_check(8'h81, 8'h42, 8'h24, 1'b0, 1'b0, 1'b0, "R8 back to 0");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_map_low();
    t_map_high();
    t_reserved();
    t_fmt_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule